// File: doc/BRIEF.md
# Period Timer with Prescaler and Postscaler

This block is an 8-bit time base with a programmable period. It runs on a system clock and advances only on cycles where an instruction-cycle enable is high and the timer is switched on. Those enabled cycles first pass through a prescaler that divides by 1, 4 or 16. Each prescaler output is one count step. On a count step the counter normally adds one. When the counter already equals the period register, the step returns it to zero instead. That step is a match.

Each match gives a one-cycle pulse on an output. A PWM unit can use this pulse to start a new period and reload its duty value, and it can read the live count as its ramp. Matches also feed a postscaler with a ratio from 1:1 to 1:16. When the postscaler reaches its terminal count, it sets a sticky interrupt flag, which stays set until it is cleared.

Software, or a neighbouring block, has a write port for each of these: the control settings (run enable, prescale select, postscale select), the counter, and the period register. Writing the control settings or the counter also clears the internal prescaler and postscaler counts, so a new period starts cleanly.

Top module: `ptmr_period_timer`

## Requirements
- R1: A synchronous active-high reset gives these values: count 0, period 0xFF, match output low, flag low, timer off, prescale 1:1, postscale 1:1.
- R2: The prescale select `ctrl_pre` uses 2'b00 for 1:1, 2'b01 for 1:4, and 2'b10 or 2'b11 for 1:16. A count step happens on every Nth cycle in which `tick_en` is high and the timer is on.
- R3: On a count step where the count is not equal to the period, the count increases by one. It wraps from 0xFF to 0x00 without a match. On a count step where the count equals the period, the count becomes 0.
- R4: The postscale select `ctrl_post` = k gives a ratio of (k+1). The flag is set on the edge of every (k+1)th match.
- R5: `match_o` is high for exactly one cycle, the cycle right after a matching count step. In that same cycle the count reads 0.
- R6: The flag stays set until `flag_clr` is high. If a new flag-setting match and a clear happen on the same edge, the set wins.
- R7: A counter write loads `cnt_wdata`, visible in the next cycle, and takes priority over a count step. A counter write or a control write clears the prescaler and postscaler counts.
- R8: A period write loads `per_wdata`, visible on `period_o` in the next cycle, and the new period is used for the following comparisons.
- R9: While the timer is off, the count and the prescaler hold their values and no match occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Instruction-cycle enable |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_on | input | 1 | Run enable value to write |
| ctrl_pre | input | 2 | Prescale select value to write |
| ctrl_post | input | 4 | Postscale select value to write (ratio = value+1) |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| per_we | input | 1 | Period write strobe |
| per_wdata | input | 8 | Period write value |
| flag_clr | input | 1 | Clears the interrupt flag |
| count_o | output | 8 | Live counter value |
| period_o | output | 8 | Period register value |
| match_o | output | 1 | One-cycle period pulse |
| flag_o | output | 1 | Sticky interrupt flag |

## Verification
Every result appears exactly one clock edge after the input that causes it:
- Writes show up in the cycle after the write strobe.
- A count step changes the count, raises `match_o` and sets the flag, all on the same edge.
- No output has more than one register between the inputs and the pins.

The bench drives inputs on the falling edge. At each rising edge a reference model computes the state that edge should produce and pushes it into a queue. A monitor pops that entry on the next falling edge and compares it against the ports, so every comparison lands exactly one edge after its cause. Directed checks count the edges the same way, which is why the prescale ratios and postscale ratios can be checked against exact edge counts.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int CNT_W  = 8;
    localparam int PRE_W  = 4;
    localparam int POST_W = 4;

    typedef enum logic [1:0] {
        PRE_DIV1  = 2'b00,
        PRE_DIV4  = 2'b01,
        PRE_DIV16 = 2'b10,
        PRE_DIV16B = 2'b11
    } pre_sel_e;

    typedef struct packed {
        logic              on;
        pre_sel_e          pre;
        logic [POST_W-1:0] post;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{on: 1'b0, pre: PRE_DIV1, post: '0};

    // Terminal prescaler count for a given select
    function automatic logic [PRE_W-1:0] pre_last(input pre_sel_e sel);
        case (sel)
            PRE_DIV1: pre_last = PRE_W'(0);
            PRE_DIV4: pre_last = PRE_W'(3);
            default:  pre_last = PRE_W'(15);
        endcase
    endfunction

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
    import ptmr_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] last,
    output logic         step
);
    logic [W-1:0] pcnt;

    assign step = adv && (pcnt == last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt <= '0;
        end else if (adv) begin
            pcnt <= step ? '0 : pcnt + W'(1);
        end
    end

    // R2
    pre_range_chk: assert property (@(posedge clk) disable iff (rst)
        pcnt <= last);

    // R2
    pre_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && !step) |=> pcnt == $past(pcnt) + W'(1));

    // R9
    pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(pcnt));

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count
    import ptmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  logic         per_we,
    input  logic [W-1:0] per_wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] per,
    output logic         wrap,
    output logic         match_q
);
    localparam logic [W-1:0] PER_RESET = '1;

    assign wrap = step && !cnt_we && (cnt == per);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            per     <= PER_RESET;
            match_q <= 1'b0;
        end else begin
            if (cnt_we) begin
                cnt <= cnt_wdata;
            end else if (step) begin
                cnt <= wrap ? '0 : cnt + W'(1);
            end
            if (per_we) begin
                per <= per_wdata;
            end
            match_q <= wrap;
        end
    end

    // R5
    match_zero_chk: assert property (@(posedge clk) disable iff (rst)
        match_q |-> cnt == '0);

    // R5
    match_single_chk: assert property (@(posedge clk) disable iff (rst)
        match_q |=> !match_q || $past(cnt == per));

    // R3
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !cnt_we && cnt != per) |=> cnt == $past(cnt) + W'(1));

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !cnt_we) |=> $stable(cnt));

    // R8
    per_load_chk: assert property (@(posedge clk) disable iff (rst)
        per_we |=> per == $past(per_wdata));

endmodule

// File: rtl/ptmr_postscale.sv
module ptmr_postscale
    import ptmr_pkg::*;
#(
    parameter int W = POST_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ev,
    input  logic [W-1:0] last,
    input  logic         flag_clr,
    output logic         flag
);
    logic [W-1:0] pcnt;
    logic         term;

    assign term = ev && (pcnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            flag <= 1'b0;
        end else begin
            if (clr) begin
                pcnt <= '0;
            end else if (ev) begin
                pcnt <= term ? '0 : pcnt + W'(1);
            end
            if (term) begin
                flag <= 1'b1;
            end else if (flag_clr) begin
                flag <= 1'b0;
            end
        end
    end

    // R4
    flag_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(ev));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    // R4
    post_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!ev && !clr) |=> $stable(pcnt));

endmodule

// File: rtl/ptmr_period_timer.sv
module ptmr_period_timer
    import ptmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PRE_W,
    parameter int QW = POST_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          ctrl_we,
    input  logic          ctrl_on,
    input  logic [1:0]    ctrl_pre,
    input  logic [QW-1:0] ctrl_post,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          per_we,
    input  logic [CW-1:0] per_wdata,
    input  logic          flag_clr,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] period_o,
    output logic          match_o,
    output logic          flag_o
);
    cfg_t          cfg_q;
    logic          adv;
    logic          step;
    logic          wrap;
    logic          scaler_clr;
    logic [PW-1:0] pre_term;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (ctrl_we) begin
            cfg_q.on   <= ctrl_on;
            cfg_q.pre  <= pre_sel_e'(ctrl_pre);
            cfg_q.post <= POST_W'(ctrl_post);
        end
    end

    assign adv        = cfg_q.on && tick_en;
    assign scaler_clr = cnt_we || ctrl_we;
    assign pre_term   = PW'(pre_last(cfg_q.pre));

    ptmr_prescale #(.W(PW)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (scaler_clr),
        .adv  (adv),
        .last (pre_term),
        .step (step)
    );

    ptmr_count #(.W(CW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .per_we    (per_we),
        .per_wdata (per_wdata),
        .cnt       (count_o),
        .per       (period_o),
        .wrap      (wrap),
        .match_q   (match_o)
    );

    ptmr_postscale #(.W(QW)) u_post (
        .clk      (clk),
        .rst      (rst),
        .clr      (scaler_clr),
        .ev       (wrap),
        .last     (QW'(cfg_q.post)),
        .flag_clr (flag_clr),
        .flag     (flag_o)
    );

    // R9
    off_no_match_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.on && !cnt_we) |=> !match_o && $stable(count_o));

    // R7
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> count_o == $past(cnt_wdata) && !match_o);

endmodule

// File: tb/ptmr_period_timer_tb_top.sv
module ptmr_period_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_en, ctrl_we, ctrl_on, cnt_we, per_we, flag_clr;
    logic [1:0] ctrl_pre;
    logic [3:0] ctrl_post;
    logic [7:0] cnt_wdata, per_wdata;
    logic [7:0] count_o, period_o;
    logic       match_o, flag_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    ptmr_period_timer dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .ctrl_we(ctrl_we), .ctrl_on(ctrl_on), .ctrl_pre(ctrl_pre), .ctrl_post(ctrl_post),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .per_we(per_we), .per_wdata(per_wdata),
        .flag_clr(flag_clr), .count_o(count_o), .period_o(period_o),
        .match_o(match_o), .flag_o(flag_o)
    );

    typedef struct packed {
        logic [7:0] cnt;
        logic [7:0] per;
        logic       match;
        logic       flag;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    int   m_pre, m_post, m_cnt, m_per, m_psel, m_qsel;
    bit   m_on, m_flag, m_match;

    function automatic int ratio(input int sel);
        if (sel == 0) return 1;
        if (sel == 1) return 4;
        return 16;
    endfunction

    always @(posedge clk) begin
        bit   step, hit, term;
        exp_t e;
        if (rst) begin
            m_pre = 0; m_post = 0; m_cnt = 0; m_per = 255;
            m_on = 0; m_psel = 0; m_qsel = 0; m_flag = 0; m_match = 0;
        end else begin
            step = m_on && tick_en && (m_pre == ratio(m_psel) - 1);
            hit  = step && !cnt_we && (m_cnt == m_per);
            term = hit && (m_post == m_qsel);
            if (cnt_we || ctrl_we) m_pre = 0;
            else if (m_on && tick_en) m_pre = step ? 0 : m_pre + 1;
            if (cnt_we) m_cnt = cnt_wdata;
            else if (step) m_cnt = hit ? 0 : (m_cnt + 1) % 256;
            if (cnt_we || ctrl_we) m_post = 0;
            else if (hit) m_post = term ? 0 : m_post + 1;
            if (term) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            m_match = hit;
            if (per_we) m_per = per_wdata;
            if (ctrl_we) begin
                m_on = ctrl_on; m_psel = ctrl_pre; m_qsel = ctrl_post;
            end
        end
        e.cnt = 8'(m_cnt); e.per = 8'(m_per); e.match = m_match; e.flag = m_flag;
        exp_q.push_back(e);
    end

    // Monitor: compare one edge after each expectation was produced
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0 && !done) begin
            e = exp_q.pop_front();
            check("R3 count", count_o, e.cnt);
            check("R8 period", period_o, e.per);
            check("R5 match", match_o, e.match);
            check("R6 flag", flag_o, e.flag);
        end
    end

    task automatic idle_inputs();
        tick_en = 0; ctrl_we = 0; ctrl_on = 0; ctrl_pre = 0; ctrl_post = 0;
        cnt_we = 0; cnt_wdata = 0; per_we = 0; per_wdata = 0; flag_clr = 0;
    endtask

    task automatic write_ctrl(input bit on, input logic [1:0] pre, input logic [3:0] post);
        ctrl_we = 1; ctrl_on = on; ctrl_pre = pre; ctrl_post = post;
        @(negedge clk);
        ctrl_we = 0;
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 count", count_o, 0);
        check("R1 period", period_o, 255);
        check("R1 flag", flag_o, 0);
        check("R1 match", match_o, 0);

        // R2: 1:4 prescale, 8 enabled cycles -> 2 steps
        write_ctrl(1, 2'b01, 0);
        tick_en = 1;
        repeat (8) @(negedge clk);
        tick_en = 0;
        check("R2 div4", count_o, 2);
        // R2: gaps in tick_en do not count
        repeat (3) @(negedge clk);
        tick_en = 1;
        repeat (4) @(negedge clk);
        tick_en = 0;
        check("R2 div4 gap", count_o, 3);

        // R9: timer off holds count
        write_ctrl(0, 2'b01, 0);
        tick_en = 1;
        repeat (10) @(negedge clk);
        check("R9 hold", count_o, 3);
        check("R9 nomatch", match_o, 0);
        tick_en = 0;

        // R7: counter write clears prescaler
        write_ctrl(1, 2'b01, 0);
        tick_en = 1;
        repeat (2) @(negedge clk);
        cnt_we = 1; cnt_wdata = 9;
        @(negedge clk);
        cnt_we = 0;
        check("R7 load", count_o, 9);
        repeat (3) @(negedge clk);
        check("R7 preclr", count_o, 9);
        @(negedge clk);
        check("R7 step", count_o, 10);
        tick_en = 0;

        // R4/R5: period 3, 1:1 prescale, 1:2 postscale
        ctrl_we = 1; ctrl_on = 1; ctrl_pre = 2'b00; ctrl_post = 4'd1;
        per_we = 1; per_wdata = 3; cnt_we = 1; cnt_wdata = 0;
        @(negedge clk);
        ctrl_we = 0; per_we = 0; cnt_we = 0;
        tick_en = 1;
        repeat (4) @(negedge clk);
        check("R5 wrapcnt", count_o, 0);
        check("R5 pulse", match_o, 1);
        check("R4 notyet", flag_o, 0);
        @(negedge clk);
        check("R5 single", match_o, 0);
        repeat (3) @(negedge clk);
        check("R4 flag", flag_o, 1);
        tick_en = 0;
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        check("R6 clear", flag_o, 0);

        // R3: wrap past 0xFF when count exceeds period
        cnt_we = 1; cnt_wdata = 8'hFE;
        @(negedge clk);
        cnt_we = 0; tick_en = 1;
        repeat (2) @(negedge clk);
        tick_en = 0;
        check("R3 ovf", count_o, 0);
        check("R3 ovf nomatch", match_o, 0);

        // Mixed stimulus, checked by the scoreboard
        for (int i = 0; i < 400; i++) begin
            tick_en  = ($urandom % 4) != 0;
            ctrl_we  = ($urandom % 40) == 0;
            ctrl_on  = ($urandom % 5) != 0;
            ctrl_pre = 2'($urandom);
            ctrl_post = 4'($urandom % 4);
            cnt_we   = ($urandom % 60) == 0;
            cnt_wdata = 8'($urandom % 12);
            per_we   = ($urandom % 50) == 0;
            per_wdata = 8'($urandom % 8);
            flag_clr = ($urandom % 10) == 0;
            @(negedge clk);
        end
        idle_inputs();
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule